// File: doc/BRIEF.md
# Guard/Round/Sticky Significand Rounder

This block rounds one unpacked significand to its target precision. The significand arrives with two extra low-order bits below its least significant bit. Bit 1 of those two is the guard bit and bit 0 is the round bit. A separate sticky bit, the value's sign and a 2-bit rounding-mode code arrive with it. The block drops the two extra bits, decides from the mode whether to add one unit in the last place, and reports whether the result is inexact and whether the increment was applied.

The increment may carry out of the top of the significand and produce 2.0. The output is one bit wider than the shifted significand so that this value is kept as it is. Renormalising it is left to the caller. The block also tells the caller, from sign and mode alone, whether an overflowing result should become infinity or the largest finite magnitude. Exponents and special-value classes are handled elsewhere. The datapath is combinational and feeds one registered stage qualified by a valid bit.

Top module: `grs_rounder`

## Requirements
- R1: When `in_valid` is high at a clock edge, the next cycle shows `out_valid` high and `out_sig` equal to `in_sig >> 2` plus the increment decision, zero-extended by one bit. When `in_valid` is low, `out_valid` is low in the next cycle.
- R2: If guard (`in_sig[1]`), round (`in_sig[0]`) and `in_sticky` are all zero, there is no increment and `out_inexact` is low.
- R3: If any of guard, round or sticky is set, `out_inexact` is high in every mode.
- R4: Mode 2'b00 (nearest) increments only when guard is set and at least one of round, sticky or the shifted LSB (`in_sig[2]`) is set, so exact ties round to even.
- R5: Mode 2'b01 (toward zero) never increments.
- R6: Mode 2'b10 (toward minus infinity) increments only inexact negative values (`in_sign`=1). Mode 2'b11 (toward plus infinity) increments only inexact positive values.
- R7: The increment carries across the full width. An all-ones shifted significand that rounds up gives `out_sig` with only its top bit set (2.0), and this value is not renormalised.
- R8: `out_rounded_up` is high exactly when the increment was applied.
- R9: `out_ovf_to_inf` is 1 in nearest mode and 0 in toward-zero mode. It equals `in_sign` in toward-minus mode and the inverse of `in_sign` in toward-plus mode.
- R10: While reset is asserted, all outputs are zero.
- R11: While `in_valid` is low, `out_sig`, `out_inexact`, `out_rounded_up` and `out_ovf_to_inf` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input qualifier |
| in_sig | input | SIG_W+2 | Significand with guard (bit 1) and round (bit 0) appended |
| in_sticky | input | 1 | OR of all bits below the round bit |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mode | input | 2 | 00 nearest, 01 toward zero, 10 toward minus, 11 toward plus |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_sig | output | SIG_W+1 | Rounded significand, top bit is the carry (2.0) |
| out_inexact | output | 1 | Any discarded bit was non-zero |
| out_rounded_up | output | 1 | The increment was applied |
| out_ovf_to_inf | output | 1 | An overflow goes to infinity (1) or to the largest finite value (0) |

## Verification
The bench builds the block with SIG_W = 8. At that width an all-ones shifted significand appears often in random stimulus, so carries through the whole width to 2.0 are exercised repeatedly as well as in directed cases. The shifted LSB and the guard/round/sticky combinations are drawn evenly, so ties, near-ties and exact values arise in all four modes and for both signs.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    localparam int EXTRA_W = 2;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_DOWN    = 2'b10,
        RM_UP      = 2'b11
    } rmode_e;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  logic       lsb,
    input  logic       guard,
    input  logic       rbit,
    input  logic       sticky,
    input  logic       sign,
    input  logic [1:0] mode,
    output logic       inc,
    output logic       inexact
);
    rmode_e m;

    always_comb begin
        m       = rmode_e'(mode);
        inexact = guard | rbit | sticky;
        inc     = 1'b0;
        if (inexact) begin
            case (m)
                RM_NEAREST: inc = guard & (rbit | sticky | lsb);
                RM_ZERO:    inc = 1'b0;
                RM_DOWN:    inc = sign;
                RM_UP:      inc = ~sign;
                default:    inc = guard & (rbit | sticky | lsb);
            endcase
        end
    end
endmodule

// File: rtl/rnd_ovf_dir.sv
module rnd_ovf_dir
    import rnd_pkg::*;
(
    input  logic       sign,
    input  logic [1:0] mode,
    output logic       to_inf
);
    always_comb begin
        case (rmode_e'(mode))
            RM_NEAREST: to_inf = 1'b1;
            RM_ZERO:    to_inf = 1'b0;
            RM_DOWN:    to_inf = sign;
            RM_UP:      to_inf = ~sign;
            default:    to_inf = 1'b1;
        endcase
    end
endmodule

// File: rtl/rnd_add.sv
module rnd_add #(
    parameter int W = 24
) (
    input  logic [W-1:0] base,
    input  logic         inc,
    output logic [W:0]   sum
);
    always_comb begin
        sum = {1'b0, base} + {{W{1'b0}}, inc};
    end
endmodule

// File: rtl/grs_rounder.sv
module grs_rounder
    import rnd_pkg::*;
#(
    parameter int SIG_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [SIG_W+EXTRA_W-1:0] in_sig,
    input  logic                     in_sticky,
    input  logic                     in_sign,
    input  logic [1:0]               in_mode,
    output logic                     out_valid,
    output logic [SIG_W:0]           out_sig,
    output logic                     out_inexact,
    output logic                     out_rounded_up,
    output logic                     out_ovf_to_inf
);
    localparam int OUT_W = SIG_W + 1;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] sig;
        logic             inexact;
        logic             up;
        logic             to_inf;
    } stage_t;

    stage_t st_d, st_q;

    logic [SIG_W-1:0] shifted;
    logic             inc_w;
    logic             inexact_w;
    logic             to_inf_w;
    logic [OUT_W-1:0] sum_w;

    assign shifted = in_sig[SIG_W+EXTRA_W-1:EXTRA_W];

    rnd_decide u_decide (
        .lsb     (in_sig[EXTRA_W]),
        .guard   (in_sig[1]),
        .rbit    (in_sig[0]),
        .sticky  (in_sticky),
        .sign    (in_sign),
        .mode    (in_mode),
        .inc     (inc_w),
        .inexact (inexact_w)
    );

    rnd_ovf_dir u_ovf (
        .sign   (in_sign),
        .mode   (in_mode),
        .to_inf (to_inf_w)
    );

    rnd_add #(.W(SIG_W)) u_add (
        .base (shifted),
        .inc  (inc_w),
        .sum  (sum_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.sig     = sum_w;
            st_d.inexact = inexact_w;
            st_d.up      = inc_w;
            st_d.to_inf  = to_inf_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.valid;
    assign out_sig        = st_q.sig;
    assign out_inexact    = st_q.inexact;
    assign out_rounded_up = st_q.up;
    assign out_ovf_to_inf = st_q.to_inf;
endmodule

// File: rtl/grs_rounder_chk.sv
module grs_rounder_chk #(
    parameter int SIG_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [SIG_W+1:0]   in_sig,
    input logic               in_sticky,
    input logic               in_sign,
    input logic [1:0]         in_mode,
    input logic               out_valid,
    input logic [SIG_W:0]     out_sig,
    input logic               out_inexact,
    input logic               out_rounded_up,
    input logic               out_ovf_to_inf
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2
    exact_no_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sig[1:0] == 2'b00 && !in_sticky) |=> (!out_inexact && !out_rounded_up));
    // R3
    inexact_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_sig[1:0] != 2'b00 || in_sticky)) |=> out_inexact);
    // R4
    nearest_no_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b00 && !in_sig[1]) |=> !out_rounded_up);
    // R5
    toward_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=> !out_rounded_up);
    // R6
    minus_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10 && !in_sign) |=> !out_rounded_up);
    // R6
    plus_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b11 && in_sign) |=> !out_rounded_up);
    // R8
    up_needs_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_rounded_up |-> out_inexact);
    // R9
    ovf_zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b01) |=> !out_ovf_to_inf);
    // R11
    hold_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sig));
endmodule

bind grs_rounder grs_rounder_chk #(.SIG_W(SIG_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_sig         (in_sig),
    .in_sticky      (in_sticky),
    .in_sign        (in_sign),
    .in_mode        (in_mode),
    .out_valid      (out_valid),
    .out_sig        (out_sig),
    .out_inexact    (out_inexact),
    .out_rounded_up (out_rounded_up),
    .out_ovf_to_inf (out_ovf_to_inf)
);

// File: tb/tb_grs_rounder.sv
`timescale 1ns/1ps
module tb_grs_rounder;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [SW+1:0] in_sig;
    logic          in_sticky;
    logic          in_sign;
    logic [1:0]    in_mode;
    logic          out_valid;
    logic [SW:0]   out_sig;
    logic          out_inexact;
    logic          out_rounded_up;
    logic          out_ovf_to_inf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    grs_rounder #(.SIG_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sig(in_sig),
        .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode),
        .out_valid(out_valid), .out_sig(out_sig), .out_inexact(out_inexact),
        .out_rounded_up(out_rounded_up), .out_ovf_to_inf(out_ovf_to_inf)
    );

    function automatic logic ref_inc(logic [SW+1:0] s, logic st, logic sg, logic [1:0] m);
        logic any;
        any = s[1] | s[0] | st;
        if (!any) return 1'b0;
        case (m)
            2'b00:   return s[1] & (s[0] | st | s[2]);
            2'b01:   return 1'b0;
            2'b10:   return sg;
            default: return ~sg;
        endcase
    endfunction

    function automatic logic ref_inf(logic sg, logic [1:0] m);
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return 1'b0;
            2'b10:   return sg;
            default: return ~sg;
        endcase
    endfunction

    task automatic chk(string tag, logic [SW:0] act, logic [SW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [SW:0] e_sig;
    logic        e_inx, e_up, e_inf;

    task automatic apply(logic [SW+1:0] s, logic st, logic sg, logic [1:0] m);
        @(negedge clk);
        in_valid = 1'b1; in_sig = s; in_sticky = st; in_sign = sg; in_mode = m;
        e_up  = ref_inc(s, st, sg, m);
        e_sig = {1'b0, s[SW+1:2]} + {{SW{1'b0}}, e_up};
        e_inx = s[1] | s[0] | st;
        e_inf = ref_inf(sg, m);
        @(negedge clk);
        chk("R1 valid", {{SW{1'b0}}, out_valid}, 1);
        chk("R1 sig", out_sig, e_sig);
        chk("R3 inexact", {{SW{1'b0}}, out_inexact}, {{SW{1'b0}}, e_inx});
        chk("R8 up", {{SW{1'b0}}, out_rounded_up}, {{SW{1'b0}}, e_up});
        chk("R9 ovf", {{SW{1'b0}}, out_ovf_to_inf}, {{SW{1'b0}}, e_inf});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        rst_n = 1'b0; in_valid = 1'b0; in_sig = '0; in_sticky = 1'b0;
        in_sign = 1'b0; in_mode = 2'b00;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset", {out_valid, out_inexact, out_rounded_up, out_ovf_to_inf, {(SW-3){1'b0}}}, '0);
        chk("R10 reset sig", out_sig, '0);
        rst_n = 1'b1;

        // R2 exact value, all modes
        for (int m = 0; m < 4; m++) begin
            apply(10'b1010110100, 1'b0, 1'b1, 2'(m));
            chk("R2 exact", {{SW{1'b0}}, out_rounded_up | out_inexact}, '0);
        end
        // R4 tie even stays, tie odd rounds
        apply(10'b1000000010, 1'b0, 1'b0, 2'b00);
        chk("R4 tie even", out_sig, 9'h080);
        apply(10'b1000000110, 1'b0, 1'b0, 2'b00);
        chk("R4 tie odd", out_sig, 9'h082);
        apply(10'b1000000001, 1'b1, 1'b0, 2'b00);
        chk("R4 below half", out_sig, 9'h080);
        // R5 toward zero
        apply(10'b1111111111, 1'b1, 1'b1, 2'b01);
        chk("R5 no inc", out_sig, 9'h0FF);
        // R6 directed modes
        apply(10'b1000000001, 1'b0, 1'b0, 2'b10);
        chk("R6 down pos", out_sig, 9'h080);
        apply(10'b1000000001, 1'b0, 1'b1, 2'b10);
        chk("R6 down neg", out_sig, 9'h081);
        apply(10'b1000000000, 1'b1, 1'b0, 2'b11);
        chk("R6 up pos", out_sig, 9'h081);
        apply(10'b1000000000, 1'b1, 1'b1, 2'b11);
        chk("R6 up neg", out_sig, 9'h080);
        // R7 carry to 2.0
        apply(10'b1111111111, 1'b0, 1'b0, 2'b00);
        chk("R7 carry", out_sig, 9'h100);
        apply(10'b1111111101, 1'b0, 1'b1, 2'b10);
        chk("R7 carry down", out_sig, 9'h100);

        // R11 hold while invalid
        @(negedge clk);
        in_valid = 1'b0; in_sig = 10'h155; in_sticky = 1'b1; in_sign = 1'b0; in_mode = 2'b01;
        @(negedge clk);
        chk("R11 valid low", {{SW{1'b0}}, out_valid}, '0);
        chk("R11 hold sig", out_sig, 9'h100);
        chk("R11 hold flags", {{(SW-2){1'b0}}, out_inexact, out_rounded_up, out_ovf_to_inf}, 9'h007);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [SW+1:0] s;
            s = SW'($urandom);
            s = {s[SW-1:0], 2'($urandom)};
            if (($urandom % 8) == 0) s[SW+1:2] = '1;
            apply(s, 1'($urandom), 1'($urandom), 2'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule